// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the bus-facing half of a byte-addressed 8192 x 8 serial memory. It runs on the system clock. It resynchronises the two-wire clock and data lines, finds start and stop conditions, and decodes a select byte. The select byte carries a fixed four-bit device code, three bits that must match the strap inputs, and a direction bit. After a write select, the block captures a two-byte memory address.

Every received data byte is handed to a separate page-write unit as a one-cycle strobe carrying the address and the data. Reads use one shared address counter and fetch bytes from storage through a read port. Three read forms are supported: current address, random read (a dummy write followed by a repeated start), and sequential read.

While the page-write unit reports that it is busy, the engine refuses its select byte. A master can poll on this to find out when the write has finished.

Top module: `i2c_mem_slave`

## Requirements
- R1: A start condition (data falling while clock is high) aborts any byte in progress and makes the engine wait for a select byte. A stop condition (data rising while clock is high) returns it to idle. A partly received address byte never loads the counter.
- R2: A select byte is acknowledged only when its upper four bits are 1010 and its next three bits equal `dev_sel_i` (bit 3 of the byte to `dev_sel_i[2]`). Bit 0 is the direction: 1 = read, 0 = write. A non-matching select gets no acknowledge.
- R3: While `busy_i` is high at the end of a select byte, the select is not acknowledged. A matching select made once `busy_i` is low is acknowledged.
- R4: After a write select, two address bytes are taken high byte first. Only the low 13 bits count, so bits 7..5 of the high byte are ignored. Each following data byte is acknowledged and emitted as a one-cycle `wr_valid_o` pulse with its address and data.
- R5: During a write, the address advances only in its low 5 bits after each data byte. It wraps inside the 32-byte page, and bits 12..5 are kept.
- R6: The counter holds the last accessed address plus one. A read select without a preceding address returns the byte at that counter.
- R7: A write select with two address bytes, followed by a repeated start and a read select, returns data from the newly loaded address.
- R8: In a read, each byte is sent MSB first. When the master acknowledges, the next byte comes from the counter plus one across the whole array, and the counter wraps from 8191 to 0.
- R9: When the master does not acknowledge a read byte, the engine releases data and drives nothing until the next start or stop.
- R10: The engine changes its data pull-down only while the synchronised clock is low.
- R11: After reset the data line is released and no write strobe is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the bus clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_pull_o | output | 1 | 1 pulls the data line low (open drain) |
| dev_sel_i | input | 3 | Strap inputs for the device select bits |
| busy_i | input | 1 | Page-write unit is busy with an internal write cycle |
| wr_valid_o | output | 1 | One-cycle strobe for a received write byte |
| wr_addr_o | output | 13 | Address of the strobed write byte |
| wr_data_o | output | 8 | Data of the strobed write byte |
| rd_addr_o | output | 13 | Current address counter, used as the storage read address |
| rd_data_i | input | 8 | Storage data at `rd_addr_o` |

## Verification
The assertions assume that a master changes the data line only while the clock is low, except when it deliberately makes a start or stop. They also assume a master never makes a start or stop while the slave is holding data low. The bench master keeps to this. It moves data late in each low phase, about seven system clocks after the clock falls, and holds the clock high for twelve system clocks. This leaves room for the two-flop synchroniser and the one-register drive update. The storage model answers the read port with a function of the address, so read data can be predicted without a memory copy.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SEL,
    ST_SEL_ACK,
    ST_AHI,
    ST_AHI_ACK,
    ST_ALO,
    ST_ALO_ACK,
    ST_WDAT,
    ST_WDAT_ACK,
    ST_RDAT,
    ST_RACK,
    ST_WAIT
  } eng_state_t;
endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic scl_held_o,
  output logic start_o,
  output logic stop_o
);
  logic [1:0] scl_pipe, sda_pipe;
  logic       scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= 2'b11;
      sda_pipe <= 2'b11;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[0], scl_i};
      sda_pipe <= {sda_pipe[0], sda_i};
      scl_q    <= scl_pipe[1];
      sda_q    <= sda_pipe[1];
    end
  end

  assign sda_s_o    = sda_pipe[1];
  assign scl_rise_o = scl_pipe[1] & ~scl_q;
  assign scl_fall_o = ~scl_pipe[1] & scl_q;
  assign scl_held_o = scl_pipe[1] & scl_q;
  assign start_o    = scl_pipe[1] & scl_q & sda_q & ~sda_pipe[1];
  assign stop_o     = scl_pipe[1] & scl_q & ~sda_q & sda_pipe[1];
endmodule

// File: rtl/i2c_addr_ctr.sv
module i2c_addr_ctr #(
  parameter int ADDR_W = 13,
  parameter int PAGE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_val_i,
  input  logic              inc_page_i,
  input  logic              inc_full_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [PAGE_W-1:0] low_sum;
  logic              en;

  always_comb begin
    low_sum = addr_q[PAGE_W-1:0] + 1'b1;
    en      = load_i | inc_page_i | inc_full_i;
    addr_d  = addr_q;
    if (load_i)          addr_d = load_val_i;
    else if (inc_page_i) addr_d = {addr_q[ADDR_W-1:PAGE_W], low_sum};
    else if (inc_full_i) addr_d = addr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  addr_q <= '0;
    else if (en) addr_q <= addr_d;
  end

  assign addr_o = addr_q;

  assert_page_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_page_i && !load_i) |=> addr_q[ADDR_W-1:PAGE_W] == $past(addr_q[ADDR_W-1:PAGE_W]));

  assert_full_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_full_i && !load_i && !inc_page_i && (&addr_q)) |=> addr_q == '0);
endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave
  import i2c_mem_pkg::*;
#(
  parameter int          ADDR_W   = 13,
  parameter int          PAGE_W   = 5,
  parameter int          SEL_W    = 3,
  parameter logic [3:0]  DEV_CODE = 4'b1010
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 scl_i,
  input  logic                 sda_i,
  output logic                 sda_pull_o,
  input  logic [SEL_W-1:0]     dev_sel_i,
  input  logic                 busy_i,
  output logic                 wr_valid_o,
  output logic [ADDR_W-1:0]    wr_addr_o,
  output logic [BYTE_W-1:0]    wr_data_o,
  output logic [ADDR_W-1:0]    rd_addr_o,
  input  logic [BYTE_W-1:0]    rd_data_i
);
  localparam int HI_W  = ADDR_W - BYTE_W;
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_RX = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_TX = CNT_W'(BYTE_W - 1);

  logic sda_s, scl_rise, scl_fall, scl_held, start_det, stop_det;

  i2c_bus_sync u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_s_o    (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .scl_held_o (scl_held),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  eng_state_t         st_q, st_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [BYTE_W-1:0]  sh_q, sh_d;
  logic [HI_W-1:0]    hi_q, hi_d;
  logic               pull_q, pull_d;
  logic               rw_q, rw_d;
  logic               mack_q, mack_d;
  logic               wv_q, wv_d;
  logic [ADDR_W-1:0]  wa_q, wa_d;
  logic [BYTE_W-1:0]  wd_q, wd_d;
  logic               ld, inc_page, inc_full;
  logic [ADDR_W-1:0]  ctr;
  logic               rx_state, sel_match;

  i2c_addr_ctr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ctr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (ld),
    .load_val_i ({hi_q, sh_q}),
    .inc_page_i (inc_page),
    .inc_full_i (inc_full),
    .addr_o     (ctr)
  );

  assign rx_state  = (st_q == ST_SEL) || (st_q == ST_AHI) ||
                     (st_q == ST_ALO) || (st_q == ST_WDAT);
  assign sel_match = (sh_q[7:4] == DEV_CODE) && (sh_q[3:1] == dev_sel_i) && !busy_i;

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    sh_d     = sh_q;
    hi_d     = hi_q;
    pull_d   = pull_q;
    rw_d     = rw_q;
    mack_d   = mack_q;
    wv_d     = 1'b0;
    wa_d     = wa_q;
    wd_d     = wd_q;
    ld       = 1'b0;
    inc_page = 1'b0;
    inc_full = 1'b0;

    if (rx_state) begin
      if (scl_rise && cnt_q < LAST_RX) begin
        sh_d  = {sh_q[BYTE_W-2:0], sda_s};
        cnt_d = cnt_q + 1'b1;
      end else if (scl_fall && cnt_q == LAST_RX) begin
        cnt_d  = '0;
        pull_d = 1'b1;
        unique case (st_q)
          ST_SEL: begin
            if (sel_match) begin
              rw_d = sh_q[0];
              st_d = ST_SEL_ACK;
            end else begin
              pull_d = 1'b0;
              st_d   = ST_WAIT;
            end
          end
          ST_AHI: begin
            hi_d = sh_q[HI_W-1:0];
            st_d = ST_AHI_ACK;
          end
          ST_ALO: begin
            ld   = 1'b1;
            st_d = ST_ALO_ACK;
          end
          default: begin
            wv_d     = 1'b1;
            wa_d     = ctr;
            wd_d     = sh_q;
            inc_page = 1'b1;
            st_d     = ST_WDAT_ACK;
          end
        endcase
      end
    end else begin
      unique case (st_q)
        ST_SEL_ACK: if (scl_fall) begin
          if (rw_q) begin
            sh_d   = rd_data_i;
            pull_d = ~rd_data_i[BYTE_W-1];
            cnt_d  = '0;
            st_d   = ST_RDAT;
          end else begin
            pull_d = 1'b0;
            st_d   = ST_AHI;
          end
        end
        ST_AHI_ACK: if (scl_fall) begin
          pull_d = 1'b0;
          st_d   = ST_ALO;
        end
        ST_ALO_ACK, ST_WDAT_ACK: if (scl_fall) begin
          pull_d = 1'b0;
          st_d   = ST_WDAT;
        end
        ST_RDAT: if (scl_fall) begin
          if (cnt_q == LAST_TX) begin
            pull_d   = 1'b0;
            cnt_d    = '0;
            inc_full = 1'b1;
            st_d     = ST_RACK;
          end else begin
            cnt_d  = cnt_q + 1'b1;
            sh_d   = {sh_q[BYTE_W-2:0], 1'b0};
            pull_d = ~sh_q[BYTE_W-2];
          end
        end
        ST_RACK: begin
          if (scl_rise) mack_d = ~sda_s;
          if (scl_fall) begin
            if (mack_q) begin
              sh_d   = rd_data_i;
              pull_d = ~rd_data_i[BYTE_W-1];
              st_d   = ST_RDAT;
            end else begin
              pull_d = 1'b0;
              st_d   = ST_WAIT;
            end
          end
        end
        default: ;
      endcase
    end

    if (start_det) begin
      st_d   = ST_SEL;
      cnt_d  = '0;
      pull_d = 1'b0;
      ld     = 1'b0;
    end else if (stop_det) begin
      st_d   = ST_IDLE;
      cnt_d  = '0;
      pull_d = 1'b0;
      ld     = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      sh_q   <= '0;
      hi_q   <= '0;
      pull_q <= 1'b0;
      rw_q   <= 1'b0;
      mack_q <= 1'b0;
      wv_q   <= 1'b0;
      wa_q   <= '0;
      wd_q   <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      hi_q   <= hi_d;
      pull_q <= pull_d;
      rw_q   <= rw_d;
      mack_q <= mack_d;
      wv_q   <= wv_d;
      wa_q   <= wa_d;
      wd_q   <= wd_d;
    end
  end

  assign sda_pull_o = pull_q;
  assign wr_valid_o = wv_q;
  assign wr_addr_o  = wa_q;
  assign wr_data_o  = wd_q;
  assign rd_addr_o  = ctr;

  assert_start_resync_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (st_q == ST_SEL) && !sda_pull_o);

  assert_stop_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (st_q == ST_IDLE) && !sda_pull_o);

  assert_busy_noack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SEL && scl_fall && cnt_q == LAST_RX && busy_i) |=> !sda_pull_o);

  assert_wr_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |=> !wr_valid_o);

  assert_quiet_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    scl_held |-> sda_pull_o == $past(sda_pull_o));
endmodule

// File: tb/test_i2c_mem_slave.sv
module test_i2c_mem_slave;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl = 1'b1;
  logic        sda_m = 1'b1;
  logic        sda_pull;
  logic        sda_line;
  logic [2:0]  dev_sel = 3'b101;
  logic        busy = 1'b0;
  logic        wr_valid;
  logic [12:0] wr_addr;
  logic [7:0]  wr_data;
  logic [12:0] rd_addr;
  logic [7:0]  rd_data;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [20:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] pat(input logic [12:0] a);
    return a[7:0] ^ {3'b000, a[12:8]} ^ 8'h5A;
  endfunction

  assign sda_line = sda_m & ~sda_pull;
  assign rd_data  = pat(rd_addr);

  i2c_mem_slave i_i2c_mem_slave (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl),
    .sda_i      (sda_line),
    .sda_pull_o (sda_pull),
    .dev_sel_i  (dev_sel),
    .busy_i     (busy),
    .wr_valid_o (wr_valid),
    .wr_addr_o  (wr_addr),
    .wr_data_o  (wr_data),
    .rd_addr_o  (rd_addr),
    .rd_data_i  (rd_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops expected write items as strobes appear
  always @(negedge clk) begin
    if (rst_n && wr_valid) begin
      if (exp_q.size() == 0) chk(1'b0, "R4 unexpected write strobe", {wr_addr, wr_data}, 0);
      else begin
        logic [20:0] e;
        e = exp_q.pop_front();
        chk({wr_addr, wr_data} == e, "R4/R5 write stream", {wr_addr, wr_data}, e);
      end
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_bit(input logic b, output logic s);
    wait_clk(7); sda_m = b;
    wait_clk(5); scl = 1'b1;
    wait_clk(6); s = sda_line;
    wait_clk(6); scl = 1'b0;
  endtask

  task automatic bus_start();
    wait_clk(7); sda_m = 1'b1;
    wait_clk(5); scl = 1'b1;
    wait_clk(6); sda_m = 1'b0;
    wait_clk(6); scl = 1'b0;
  endtask

  task automatic bus_stop();
    wait_clk(7); sda_m = 1'b0;
    wait_clk(5); scl = 1'b1;
    wait_clk(6); sda_m = 1'b1;
    wait_clk(12);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    logic s;
    for (int i = 7; i >= 0; i--) bus_bit(b[i], s);
    bus_bit(1'b1, s);
    acked = ~s;
  endtask

  task automatic read_byte(input bit give_ack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bus_bit(1'b1, s);
      d[i] = s;
    end
    bus_bit(~give_ack, s);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    bit a;
    logic [7:0] d;
    logic s;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    // R11: released line and no strobe after reset
    chk(sda_pull == 1'b0, "R11 reset pull", sda_pull, 0);
    chk(wr_valid == 1'b0, "R11 reset strobe", wr_valid, 0);

    // R2/R4/R5: page write starting at 0x031E (high byte top bits ignored)
    exp_q.push_back({13'h031E, 8'hAA});
    exp_q.push_back({13'h031F, 8'hBB});
    exp_q.push_back({13'h0300, 8'hCC});
    exp_q.push_back({13'h0301, 8'hDD});
    bus_start();
    send_byte(8'hAA, a); chk(a, "R2 matching write select ack", a, 1);
    send_byte(8'hE3, a); chk(a, "R4 address high ack", a, 1);
    send_byte(8'h1E, a); chk(a, "R4 address low ack", a, 1);
    send_byte(8'hAA, a); chk(a, "R4 data ack", a, 1);
    send_byte(8'hBB, a);
    send_byte(8'hCC, a); chk(a, "R5 data ack after page wrap", a, 1);
    send_byte(8'hDD, a);
    bus_stop();
    chk(exp_q.size() == 0, "R5 all write bytes seen", exp_q.size(), 0);

    // R6/R9: current address read at 0x0302, master declines
    bus_start();
    send_byte(8'hAB, a); chk(a, "R6 read select ack", a, 1);
    read_byte(1'b0, d);
    chk(d == pat(13'h0302), "R6 current address data", d, pat(13'h0302));
    bus_bit(1'b1, s);
    chk(s == 1'b1 && sda_pull == 1'b0, "R9 released after no-ack", s, 1);
    bus_stop();

    // R2: wrong straps
    bus_start();
    send_byte(8'hA2, a); chk(!a, "R2 wrong strap no ack", a, 0);
    bus_stop();

    // R3: busy polling
    busy = 1'b1;
    bus_start();
    send_byte(8'hAA, a); chk(!a, "R3 busy no ack", a, 0);
    bus_stop();
    busy = 1'b0;
    bus_start();
    send_byte(8'hAA, a); chk(a, "R3 ack once idle", a, 1);
    bus_stop();

    // R7/R8: random read at 0x1FFE, sequential across the wrap
    bus_start();
    send_byte(8'hAA, a);
    send_byte(8'h1F, a);
    send_byte(8'hFE, a);
    bus_start();
    send_byte(8'hAB, a); chk(a, "R7 read select after repeated start", a, 1);
    read_byte(1'b1, d); chk(d == pat(13'h1FFE), "R7 random read data", d, pat(13'h1FFE));
    read_byte(1'b1, d); chk(d == pat(13'h1FFF), "R8 sequential next", d, pat(13'h1FFF));
    read_byte(1'b0, d); chk(d == pat(13'h0000), "R8 wrap to zero", d, pat(13'h0000));
    bus_stop();

    bus_start();
    send_byte(8'hAB, a);
    read_byte(1'b0, d); chk(d == pat(13'h0001), "R6 counter after wrap", d, pat(13'h0001));
    bus_stop();

    // R1: abort mid address byte with a start; counter must be untouched
    bus_start();
    send_byte(8'hAA, a);
    send_byte(8'h00, a);
    bus_bit(1'b1, s); bus_bit(1'b0, s); bus_bit(1'b1, s);
    bus_start();
    send_byte(8'hAB, a); chk(a, "R1 select after abort", a, 1);
    read_byte(1'b0, d); chk(d == pat(13'h0002), "R1 partial address ignored", d, pat(13'h0002));
    bus_stop();

    // R1: stop inside a data byte produces no strobe
    bus_start();
    send_byte(8'hAA, a);
    send_byte(8'h00, a);
    send_byte(8'h40, a);
    bus_bit(1'b0, s); bus_bit(1'b1, s);
    bus_stop();
    wait_clk(10);
    chk(exp_q.size() == 0, "R1 no pending writes", exp_q.size(), 0);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule